// File: doc/BRIEF.md
# Load Dependency Tracker

This block follows register-level dependencies through an in-order stream of instructions that have already been decoded. For every integer register, every floating-point register and every tracked floating-point control unit, it holds a bitmask of the outstanding load tags that the current value was derived from. A tag is allocated to each load or atomic as it arrives. The tag stays in the masks until an external retire pulse clears it.

When a memory instruction is presented, the block reports three masks one cycle later. The address mask gives the loads that the base register depends on. The data mask gives the loads that the stored value depends on. The control mask gives the loads that any earlier branch or indirect jump depended on. A scheduler or ordering checker uses these masks to decide which earlier loads a memory operation must wait behind.

Propagation follows fixed carry rules. Loads, atomics and indirect jumps do not pass their source masks to their destination. Integer register zero never holds or passes a dependency. Control-register accesses skip the read or the write in certain encodings. The five floating-point exception flags are separate accumulating units, and the whole-control register is an alias of the flags and the rounding mode.

Top module: `dep_tracker`

## Requirements
- R1: Integer register 0 always has an empty mask. Writing it has no effect, and using it as a source contributes nothing.
- R2: A load (class 5), an atomic (class 7) or an FP load (class 9) sets its destination mask to exactly the one-hot bit of `in_tag`. An indirect jump (class 4) clears its integer destination mask. None of these passes its source masks to its destination.
- R3: For every memory class, `addr_dep` is the mask of integer rs1. `data_dep` is the integer rs2 mask for a store (class 6) or an atomic (class 7), and the FP rs2 mask for an FP store (class 10). `data_dep` is zero for loads.
- R4: An ALU instruction (class 1) sets integer rd to the OR of the integer rs1 and rs2 masks. An instruction presented in the next cycle sees the new mask. A constant-producing instruction (class 2) clears rd.
- R5: A branch (class 3) or an indirect jump (class 4) ORs the masks of its integer sources into a control mask. That mask is reported as `ctrl_dep` on every later memory operation.
- R6: Each set bit of `retire` removes that tag at the clock edge from every register mask, every control-unit mask and the control mask.
- R7: For a control-register access (class 8), op 01 (write) always writes. Ops 10 (set) and 11 (clear) write only when the rs1 field (register or immediate) is non-zero.
- R8: A control-register write gives the target units the integer rs1 mask, or an empty mask when `in_csr_imm` is 1. A read gives integer rd the mask of the CSR as it stood before the instruction.
- R9: CSR address 0x001 covers the five flag units, 0x002 covers the rounding-mode unit, and 0x003 covers all six. A read returns the OR of the covered units, and a write updates all of them.
- R10: An FP operation (class 11) ORs its source mask into each flag unit whose bit is set in `in_flags`, where bit k is flag bit k. It writes that source mask, without any flag masks, to its destination.
- R11: An FP operation adds the rounding-mode unit to its source mask only when `in_rm_dyn` is 1.
- R12: `out_vld` goes high exactly one cycle after a valid memory instruction (classes 5, 6, 7, 9 and 10) and is low otherwise. The three masks are registered with it, and all outputs reset to zero.
- R13: FP registers form a separate file in which register 0 is an ordinary register. `in_fp_sel` bits 0, 1, 2 and 3 choose the FP file for rs1, rs2, rs3 and rd of an FP operation, and `in_src_use` bits 0 to 2 enable rs1 to rs3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Instruction present this cycle |
| in_cls | input | 4 | Instruction class code |
| in_rs1 | input | 5 | Source 1 index, or immediate for CSR immediate forms |
| in_rs2 | input | 5 | Source 2 index |
| in_rs3 | input | 5 | Source 3 index (FP operations) |
| in_rd | input | 5 | Destination index |
| in_csr | input | 12 | CSR address |
| in_csr_op | input | 2 | CSR op: 01 write, 10 set, 11 clear, 00 none |
| in_csr_imm | input | 1 | CSR immediate form |
| in_fp_sel | input | 4 | FP-file select for rs1, rs2, rs3, rd |
| in_src_use | input | 3 | Source enables for FP operations |
| in_rm_dyn | input | 1 | FP operation uses the dynamic rounding mode |
| in_flags | input | 5 | Flags the FP operation can raise |
| in_tag | input | 3 | Tag allocated to a load or atomic |
| retire | input | 8 | Tags freed this cycle |
| out_vld | output | 1 | Dependency report valid |
| addr_dep | output | 8 | Address dependency mask |
| data_dep | output | 8 | Data dependency mask |
| ctrl_dep | output | 8 | Control dependency mask |

## Verification
The assertions assume that `in_cls` carries one of the listed codes and that memory inputs are defined whenever `in_vld` is high. They also assume that no tag is allocated while its retire bit is pulsed. The stimulus presents one decoded instruction per cycle and pulses retire only in idle cycles. It allocates each tag once until that tag is retired, so every expected mask follows directly from the requirements.

// File: rtl/dep_tracker.sv
module dep_tracker #(
  parameter int NTAG = 8,
  parameter int NREG = 32,
  parameter int CSRW = 12,
  parameter logic [CSRW-1:0] A_FLAGS = 12'h001,
  parameter logic [CSRW-1:0] A_RMODE = 12'h002,
  parameter logic [CSRW-1:0] A_FPCTL = 12'h003
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic [3:0]              in_cls,
  input  logic [$clog2(NREG)-1:0] in_rs1,
  input  logic [$clog2(NREG)-1:0] in_rs2,
  input  logic [$clog2(NREG)-1:0] in_rs3,
  input  logic [$clog2(NREG)-1:0] in_rd,
  input  logic [CSRW-1:0]         in_csr,
  input  logic [1:0]              in_csr_op,
  input  logic                    in_csr_imm,
  input  logic [3:0]              in_fp_sel,
  input  logic [2:0]              in_src_use,
  input  logic                    in_rm_dyn,
  input  logic [4:0]              in_flags,
  input  logic [$clog2(NTAG)-1:0] in_tag,
  input  logic [NTAG-1:0]         retire,
  output logic                    out_vld,
  output logic [NTAG-1:0]         addr_dep,
  output logic [NTAG-1:0]         data_dep,
  output logic [NTAG-1:0]         ctrl_dep
);
  localparam int NFL = 5;
  localparam logic [3:0] C_ALU = 4'd1, C_CONST = 4'd2, C_BR = 4'd3, C_JALR = 4'd4,
                         C_LOAD = 4'd5, C_STORE = 4'd6, C_AMO = 4'd7, C_CSR = 4'd8,
                         C_FLOAD = 4'd9, C_FSTORE = 4'd10, C_FPU = 4'd11;
  localparam logic [1:0] OP_W = 2'b01;

  logic [NREG-1:0][NTAG-1:0] xr, xr_n, fr, fr_n;
  logic [NFL:0][NTAG-1:0]    cu, cu_n;
  logic [NTAG-1:0]           ctrl_q, ctrl_n;

  logic [NTAG-1:0] tag_oh, fs1, fs2, fs3, fp_src, flag_or, csr_rv, csr_wv, data_c;
  logic            is_mem, hit_fl, hit_rm, csr_rd, csr_wr;

  assign tag_oh = {{(NTAG-1){1'b0}}, 1'b1} << in_tag;
  assign is_mem = in_cls inside {C_LOAD, C_STORE, C_AMO, C_FLOAD, C_FSTORE};

  assign fs1 = !in_src_use[0] ? '0 : in_fp_sel[0] ? fr[in_rs1] : xr[in_rs1];
  assign fs2 = !in_src_use[1] ? '0 : in_fp_sel[1] ? fr[in_rs2] : xr[in_rs2];
  assign fs3 = !in_src_use[2] ? '0 : in_fp_sel[2] ? fr[in_rs3] : xr[in_rs3];
  assign fp_src = fs1 | fs2 | fs3 | (in_rm_dyn ? cu[NFL] : '0);

  always_comb begin
    flag_or = '0;
    for (int k = 0; k < NFL; k++) flag_or |= cu[k];
  end

  assign hit_fl = (in_csr == A_FLAGS) || (in_csr == A_FPCTL);
  assign hit_rm = (in_csr == A_RMODE) || (in_csr == A_FPCTL);
  assign csr_rv = (hit_fl ? flag_or : '0) | (hit_rm ? cu[NFL] : '0);
  assign csr_wv = in_csr_imm ? '0 : xr[in_rs1];
  assign csr_rd = (in_csr_op == OP_W) ? (in_rd != '0) : 1'b1;
  assign csr_wr = (in_csr_op == OP_W) || (in_rs1 != '0);

  assign data_c = (in_cls == C_STORE || in_cls == C_AMO) ? xr[in_rs2] :
                  (in_cls == C_FSTORE) ? fr[in_rs2] : '0;

  always_comb begin
    xr_n = xr;
    fr_n = fr;
    cu_n = cu;
    ctrl_n = ctrl_q;
    if (in_vld) begin
      case (in_cls)
        C_ALU:   xr_n[in_rd] = xr[in_rs1] | xr[in_rs2];
        C_CONST: xr_n[in_rd] = '0;
        C_BR:    ctrl_n = ctrl_q | xr[in_rs1] | xr[in_rs2];
        C_JALR: begin
          ctrl_n = ctrl_q | xr[in_rs1];
          xr_n[in_rd] = '0;
        end
        C_LOAD, C_AMO: xr_n[in_rd] = tag_oh;
        C_FLOAD:       fr_n[in_rd] = tag_oh;
        C_CSR: if (in_csr_op != 2'b00) begin
          if (csr_wr) begin
            for (int k = 0; k < NFL; k++) if (hit_fl) cu_n[k] = csr_wv;
            if (hit_rm) cu_n[NFL] = csr_wv;
          end
          if (csr_rd) xr_n[in_rd] = csr_rv;
        end
        C_FPU: begin
          for (int k = 0; k < NFL; k++) if (in_flags[k]) cu_n[k] = cu[k] | fp_src;
          if (in_fp_sel[3]) fr_n[in_rd] = fp_src;
          else              xr_n[in_rd] = fp_src;
        end
        default: ;
      endcase
    end
    xr_n[0] = '0;
    for (int i = 0; i < NREG; i++) begin
      xr_n[i] &= ~retire;
      fr_n[i] &= ~retire;
    end
    for (int k = 0; k <= NFL; k++) cu_n[k] &= ~retire;
    ctrl_n &= ~retire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xr <= '0;
      fr <= '0;
      cu <= '0;
      ctrl_q <= '0;
      out_vld <= 1'b0;
      addr_dep <= '0;
      data_dep <= '0;
      ctrl_dep <= '0;
    end else begin
      xr <= xr_n;
      fr <= fr_n;
      cu <= cu_n;
      ctrl_q <= ctrl_n;
      out_vld <= in_vld && is_mem;
      addr_dep <= (in_vld && is_mem) ? xr[in_rs1] : '0;
      data_dep <= (in_vld && is_mem) ? data_c : '0;
      ctrl_dep <= (in_vld && is_mem) ? ctrl_q : '0;
    end
  end

  a_r12_report_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && is_mem) |=> out_vld);
  a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_vld && is_mem) |=> !out_vld);
  a_r3_load_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (in_cls == C_LOAD || in_cls == C_FLOAD)) |=> (data_dep == '0));
  a_r1_zero_base: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && is_mem && in_rs1 == '0) |=> (addr_dep == '0));
  a_r6_ctrl_retired: assert property (@(posedge clk) disable iff (!rst_n)
    (|retire) |=> ((ctrl_q & $past(retire)) == '0));
  a_r5_ctrl_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(|retire) |=> ((ctrl_q & $past(ctrl_q)) == $past(ctrl_q)));
endmodule

// File: tb/dep_tracker_test.sv
`timescale 1ns/1ps
module dep_tracker_test;
  logic clk = 0, rst_n = 0;
  logic in_vld = 0, in_csr_imm = 0, in_rm_dyn = 0;
  logic [3:0] in_cls = 0, in_fp_sel = 0;
  logic [4:0] in_rs1 = 0, in_rs2 = 0, in_rs3 = 0, in_rd = 0, in_flags = 0;
  logic [11:0] in_csr = 0;
  logic [1:0] in_csr_op = 0;
  logic [2:0] in_src_use = 0, in_tag = 0;
  logic [7:0] retire = 0;
  logic out_vld;
  logic [7:0] addr_dep, data_dep, ctrl_dep;

  typedef struct packed { logic [7:0] a, d, c; } exp_t;
  exp_t q[$];
  string qr[$];
  exp_t e;
  string er;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dep_tracker uut (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_cls(in_cls),
    .in_rs1(in_rs1), .in_rs2(in_rs2), .in_rs3(in_rs3), .in_rd(in_rd), .in_csr(in_csr),
    .in_csr_op(in_csr_op), .in_csr_imm(in_csr_imm), .in_fp_sel(in_fp_sel),
    .in_src_use(in_src_use), .in_rm_dyn(in_rm_dyn), .in_flags(in_flags), .in_tag(in_tag),
    .retire(retire), .out_vld(out_vld), .addr_dep(addr_dep), .data_dep(data_dep),
    .ctrl_dep(ctrl_dep));

  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R12 unexpected report a=%h d=%h c=%h, expected none", addr_dep, data_dep, ctrl_dep);
      end else begin
        e = q.pop_front();
        er = qr.pop_front();
        if ({addr_dep, data_dep, ctrl_dep} !== {e.a, e.d, e.c}) begin
          errors++;
          $display("FAIL %s a=%h d=%h c=%h, expected a=%h d=%h c=%h",
                   er, addr_dep, data_dep, ctrl_dep, e.a, e.d, e.c);
        end
      end
    end
  end

  task automatic drive(input logic [3:0] c, input logic [4:0] r1, r2, r3, rd,
                       input logic [11:0] csr, input logic [1:0] op, input logic imm,
                       input logic [3:0] fs, input logic [2:0] use_, input logic rm,
                       input logic [4:0] fl, input logic [2:0] tg);
    in_vld = 1; in_cls = c; in_rs1 = r1; in_rs2 = r2; in_rs3 = r3; in_rd = rd;
    in_csr = csr; in_csr_op = op; in_csr_imm = imm; in_fp_sel = fs;
    in_src_use = use_; in_rm_dyn = rm; in_flags = fl; in_tag = tg;
    @(negedge clk);
    in_vld = 0;
  endtask

  task automatic expect_(input logic [7:0] a, d, c, input string rq);
    q.push_back('{a: a, d: d, c: c});
    qr.push_back(rq);
  endtask

  task automatic ld(input logic [4:0] rd, r1, input logic [2:0] tg, input logic [7:0] ea, ec, input string rq);
    expect_(ea, 8'h00, ec, rq); drive(5, r1, 0, 0, rd, 0, 0, 0, 0, 0, 0, 0, tg);
  endtask
  task automatic st(input logic [4:0] r1, r2, input logic [7:0] ea, ed, ec, input string rq);
    expect_(ea, ed, ec, rq); drive(6, r1, r2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic amo(input logic [4:0] rd, r1, r2, input logic [2:0] tg, input logic [7:0] ea, ed, ec, input string rq);
    expect_(ea, ed, ec, rq); drive(7, r1, r2, 0, rd, 0, 0, 0, 0, 0, 0, 0, tg);
  endtask
  task automatic fld(input logic [4:0] rd, r1, input logic [2:0] tg, input logic [7:0] ea, ec, input string rq);
    expect_(ea, 8'h00, ec, rq); drive(9, r1, 0, 0, rd, 0, 0, 0, 0, 0, 0, 0, tg);
  endtask
  task automatic fst(input logic [4:0] r1, r2, input logic [7:0] ea, ed, ec, input string rq);
    expect_(ea, ed, ec, rq); drive(10, r1, r2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic alu(input logic [4:0] rd, r1, r2); drive(1, r1, r2, 0, rd, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic cst(input logic [4:0] rd); drive(2, 0, 0, 0, rd, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic br(input logic [4:0] r1, r2); drive(3, r1, r2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic jalr(input logic [4:0] rd, r1); drive(4, r1, 0, 0, rd, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic csr(input logic [1:0] op, input logic imm, input logic [11:0] ad, input logic [4:0] rd, r1);
    drive(8, r1, 0, 0, rd, ad, op, imm, 0, 0, 0, 0, 0);
  endtask
  task automatic fpu(input logic [3:0] fs, input logic [2:0] u, input logic [4:0] rd, r1, r2, r3,
                     input logic rm, input logic [4:0] fl);
    drive(11, r1, r2, r3, rd, 0, 0, 0, fs, u, rm, fl, 0);
  endtask
  task automatic ret(input logic [7:0] m);
    retire = m; @(negedge clk); retire = 0;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_vld !== 0 || addr_dep !== 0 || data_dep !== 0 || ctrl_dep !== 0) begin
      errors++;
      $display("FAIL R12 reset outputs v=%b a=%h d=%h c=%h, expected all zero", out_vld, addr_dep, data_dep, ctrl_dep);
    end
    rst_n = 1;
    @(negedge clk);
    // R2 load tags, R1 zero base
    ld(5, 0, 0, 8'h00, 8'h00, "R1 load base x0");
    ld(6, 5, 1, 8'h01, 8'h00, "R2 load addr from x5");
    st(6, 5, 8'h02, 8'h01, 8'h00, "R3 store addr/data");
    alu(7, 5, 6);
    st(7, 0, 8'h03, 8'h00, 8'h00, "R4 alu OR of sources");
    alu(0, 5, 6);
    st(0, 0, 8'h00, 8'h00, 8'h00, "R1 write to x0 ignored");
    cst(7);
    st(7, 7, 8'h00, 8'h00, 8'h00, "R4 constant clears rd");
    ld(8, 7, 2, 8'h00, 8'h00, "R2 load tag2");
    jalr(9, 8);
    st(9, 9, 8'h00, 8'h00, 8'h04, "R5 jalr ctrl, R2 jalr rd empty");
    ld(10, 5, 3, 8'h01, 8'h04, "R5 ctrl on later load");
    br(10, 0);
    amo(11, 6, 10, 4, 8'h02, 8'h08, 8'h0C, "R3 amo data, R5 branch accumulates");
    ret(8'h0C);
    st(10, 11, 8'h00, 8'h10, 8'h00, "R6 retire clears regs and ctrl");
    // CSR rules
    csr(2'b01, 0, 12'h001, 0, 11);
    csr(2'b10, 0, 12'h001, 12, 0);
    csr(2'b10, 0, 12'h001, 13, 0);
    st(13, 12, 8'h10, 8'h10, 8'h00, "R7 set with rs1=x0 does not write, R8 read");
    csr(2'b10, 1, 12'h001, 14, 0);
    csr(2'b11, 1, 12'h001, 15, 5);
    csr(2'b10, 0, 12'h001, 16, 0);
    st(16, 15, 8'h00, 8'h10, 8'h00, "R7 clear-imm writes, R8 imm writes empty");
    st(14, 0, 8'h10, 8'h00, 8'h00, "R7 set-imm zero no write");
    alu(17, 6, 0);
    csr(2'b01, 0, 12'h002, 0, 17);
    csr(2'b10, 0, 12'h001, 18, 0);
    csr(2'b10, 0, 12'h003, 19, 0);
    st(18, 0, 8'h00, 8'h00, 8'h00, "R9 frm write not in fflags");
    st(19, 0, 8'h02, 8'h00, 8'h00, "R9 fcsr read includes frm");
    csr(2'b01, 0, 12'h003, 0, 11);
    csr(2'b10, 0, 12'h002, 20, 0);
    st(20, 19, 8'h10, 8'h02, 8'h00, "R9 fcsr write reaches frm");
    csr(2'b01, 1, 12'h003, 0, 0);
    csr(2'b10, 0, 12'h003, 21, 0);
    st(21, 0, 8'h00, 8'h00, 8'h00, "R8 write-imm always writes empty");
    // FP
    fld(1, 0, 5, 8'h00, 8'h00, "R2 fp load tag5");
    fld(0, 0, 6, 8'h00, 8'h00, "R13 f0 load tag6");
    fpu(4'b1011, 3'b011, 2, 1, 0, 0, 0, 5'b00101);
    fst(0, 2, 8'h00, 8'h60, 8'h00, "R13 f0 is a real source");
    csr(2'b10, 0, 12'h001, 21, 0);
    st(21, 0, 8'h60, 8'h00, 8'h00, "R10 flags take fp sources");
    csr(2'b01, 1, 12'h001, 0, 0);
    fpu(4'b1001, 3'b001, 3, 1, 0, 0, 0, 5'b00001);
    fpu(4'b1001, 3'b001, 4, 0, 0, 0, 0, 5'b00001);
    csr(2'b10, 0, 12'h001, 22, 0);
    st(22, 0, 8'h60, 8'h00, 8'h00, "R10 flag accumulates own value");
    fst(0, 4, 8'h00, 8'h40, 8'h00, "R10 rd excludes flags");
    csr(2'b01, 0, 12'h002, 0, 5);
    fpu(4'b0001, 3'b001, 23, 1, 0, 0, 1, 5'b00000);
    st(23, 0, 8'h21, 8'h00, 8'h00, "R11 dynamic rm reads frm");
    fpu(4'b0001, 3'b001, 24, 1, 0, 0, 0, 5'b00000);
    st(24, 0, 8'h20, 8'h00, 8'h00, "R11 static rm skips frm");
    br(5, 0);
    ld(25, 0, 7, 8'h00, 8'h01, "R5 ctrl from branch on x5");
    ret(8'hFF);
    st(23, 24, 8'h00, 8'h00, 8'h00, "R6 retire all");
    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R12 reports missing: %0d left, expected 0", q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule